// File: doc/BRIEF.md
# Grid Processing Element with Three-Way Operand Sourcing

This block is a single processing element of a two-dimensional array of functional units. A row pipeline register ahead of the element supplies an operation code, two operand-source selects and a handful of write controls each cycle. The element gathers each of its two operands from a global register read value, from one of the two scratch registers of a neighbouring element, or from its own result register. It then applies a simple integer operation to them.

Every executed operation lands in a private result register one clock later. The same value can also go into one of the element's two local scratch registers, and it can be offered as a write request to the shared 32-entry global register file. Loads and stores appear only as address arithmetic: the sum of the operands goes to the result register, and a flag marks it as a memory address. A valid bit gates all of this, so an idle slot changes no state.

Top module: `mfu_cell`

## Requirements
- R1: A synchronous active-low reset clears the result register, both scratch registers, the global write request and the address flag to zero.
- R2: Operand select code 00 picks that operand's global register read value.
- R3: Select codes 01 and 10 pick scratch register 0 or 1 of the neighbour named by that operand's unit index. Neighbour u's scratch register t sits at bits [(2u+t)*W +: W] of the neighbour bus.
- R4: Select code 11 picks the element's own result register, so consecutive operations can chain without touching any register file.
- R5: Opcodes are 000 add, 001 subtract (operand 1 minus operand 2), 010 AND, 011 OR, 100 XOR, 101 shift left, 110 logical shift right and 111 pass operand 1. A shift amount comes from the low log2(W) bits of operand 2.
- R6: Every valid operation updates the result register on the next rising clock edge.
- R7: With the valid bit low, the result register and scratch registers keep their values. No global write is requested and no address is flagged, whatever the other inputs carry.
- R8: A valid operation with the scratch write enable set stores its result into the scratch register chosen by the 1-bit index on the same edge as the result register. The other scratch register is left unchanged. Scratch register 0 appears at bits [W-1:0] of the scratch output.
- R9: A valid operation with a global write request raises the write strobe for exactly one cycle. That cycle is the same one in which the result register shows the new value, and the strobe comes with the 5-bit register index and the result as write data.
- R10: A valid operation marked as memory access raises the address flag for one cycle alongside the updated result register, which then holds the computed address.
- R11: Add and subtract wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Slot carries an operation |
| op_code_i | input | 3 | Operation code |
| src1_sel_i | input | 2 | Operand 1 source select |
| src2_sel_i | input | 2 | Operand 2 source select |
| src1_unit_i | input | UNIT_W | Neighbour index for operand 1 scratch reads |
| src2_unit_i | input | UNIT_W | Neighbour index for operand 2 scratch reads |
| grf_rd1_i | input | W | Global register value for operand 1 |
| grf_rd2_i | input | W | Global register value for operand 2 |
| nbr_tmp_i | input | NBR*2*W | Scratch registers of the neighbouring elements |
| tmp_we_i | input | 1 | Write the result into a scratch register |
| tmp_widx_i | input | 1 | Scratch register to write |
| grf_req_i | input | 1 | Request a global register write |
| grf_idx_i | input | 5 | Global register index to write |
| mem_op_i | input | 1 | Operation is an address computation |
| res_o | output | W | Result register |
| tmp_o | output | 2*W | Own scratch registers, register 0 in the low half |
| grf_we_o | output | 1 | Global write strobe |
| grf_widx_o | output | 5 | Global write index |
| grf_wdata_o | output | W | Global write data |
| addr_valid_o | output | 1 | Result register holds a memory address |

## Verification
The bench builds the element with a 16-bit datapath and two neighbours. With a 16-bit datapath, carries out of bit 15 and borrows below zero can be forced. Every shift amount from 0 to 15 is reachable, and operand-2 bits above the shift field can be shown to be ignored. With two neighbours, both scratch registers of both neighbour indices can be driven with distinct values, so a wrong slot or unit decode shows up as a wrong result.

// File: rtl/mfu_pkg.sv
// Package: shared encodings for the grid processing element.
// Assumes: the opcode is 3 bits and the source select is 2 bits.
package mfu_pkg;

    // Operation encodings
    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_SHL  = 3'b101,
        OP_SHR  = 3'b110,
        OP_PASS = 3'b111
    } op_e;

    // Operand source encodings
    typedef enum logic [1:0] {
        SRC_GRF  = 2'b00,
        SRC_TMP0 = 2'b01,
        SRC_TMP1 = 2'b10,
        SRC_OWN  = 2'b11
    } src_e;

endpackage

// File: rtl/mfu_opsel.sv
// Module: mfu_opsel
// Selects one operand from the global read value, a neighbour's scratch
// register, or the element's own result register.
// Assumes: neighbour u, register t sits at bits [(2u+t)*W +: W] of nbr_tmp_i;
// an out-of-range unit index yields zero.
module mfu_opsel
    import mfu_pkg::*;
#(
    parameter int W      = 16,
    parameter int NBR    = 2,
    parameter int UNIT_W = 1
) (
    input  logic [1:0]         sel_i,
    input  logic [UNIT_W-1:0]  unit_i,
    input  logic [W-1:0]       grf_i,
    input  logic [NBR*2*W-1:0] nbr_tmp_i,
    input  logic [W-1:0]       own_i,
    output logic [W-1:0]       opnd_o
);

    localparam int SLOTS = NBR * 2;

    logic [W-1:0] nbr_word;

    // Pick the neighbour scratch word addressed by unit and slot
    always_comb begin
        nbr_word = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if ((int'(unit_i) == s / 2) &&
                ((s % 2 == 1) == (src_e'(sel_i) == SRC_TMP1))) begin
                nbr_word = nbr_tmp_i[s*W +: W];
            end
        end
    end

    // Route the chosen source onto the operand
    always_comb begin
        unique case (src_e'(sel_i))
            SRC_GRF:            opnd_o = grf_i;
            SRC_TMP0, SRC_TMP1: opnd_o = nbr_word;
            SRC_OWN:            opnd_o = own_i;
            default:            opnd_o = '0;
        endcase
    end

endmodule

// File: rtl/mfu_alu.sv
// Module: mfu_alu
// Combinational integer unit: add, subtract, bitwise logic, shifts, pass.
// Assumes: the shift amount is the low log2(W) bits of operand b; arithmetic wraps.
module mfu_alu
    import mfu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    localparam int SHW = (W > 1) ? $clog2(W) : 1;

    logic [SHW-1:0] shamt;

    // Extract the shift distance
    always_comb shamt = b_i[SHW-1:0];

    // Evaluate the selected operation
    always_comb begin
        unique case (op_e'(op_i))
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_SHL:  y_o = a_i << shamt;
            OP_SHR:  y_o = a_i >> shamt;
            OP_PASS: y_o = a_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/mfu_tmpfile.sv
// Module: mfu_tmpfile
// Two private scratch registers with a single write port.
// Assumes: the writer has already qualified we_i with the valid bit.
module mfu_tmpfile #(
    parameter int W    = 16,
    parameter int REGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              idx_i,
    input  logic [W-1:0]      wdata_i,
    output logic [REGS*W-1:0] rd_o
);

    logic [W-1:0] regs_q [REGS];

    // Clear on reset, otherwise write the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS; r++) regs_q[r] <= '0;
        end else if (we_i) begin
            regs_q[int'(idx_i)] <= wdata_i;
        end
    end

    // Flatten the registers onto the read bus
    generate
        for (genvar g = 0; g < REGS; g++) begin : g_rd
            assign rd_o[g*W +: W] = regs_q[g];
        end
    endgenerate

    // R8: a write to register 0 leaves register 1 untouched
    assert_tmp0_write_spares_tmp1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !idx_i) |=> $stable(regs_q[1]));

    // R8: a write to register 1 leaves register 0 untouched
    assert_tmp1_write_spares_tmp0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i) |=> $stable(regs_q[0]));

    // R8: the written register takes the write data
    assert_tmp_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rd_o[$past(int'(idx_i))*W +: W] == $past(wdata_i)));

endmodule

// File: rtl/mfu_cell.sv
// Module: mfu_cell
// One processing element of the functional-unit grid. It selects two
// operands, computes a result, always latches it into the result register,
// and optionally writes a scratch register and requests a global write.
// Assumes: controls come from the row pipeline register; the global file
// and the neighbour scratch registers sit outside this block.
module mfu_cell
    import mfu_pkg::*;
#(
    parameter int W          = 16,
    parameter int NBR        = 2,
    parameter int GRF_DEPTH  = 32,
    parameter int UNIT_W     = (NBR > 1) ? $clog2(NBR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid_i,
    input  logic [2:0]                    op_code_i,
    input  logic [1:0]                    src1_sel_i,
    input  logic [1:0]                    src2_sel_i,
    input  logic [UNIT_W-1:0]             src1_unit_i,
    input  logic [UNIT_W-1:0]             src2_unit_i,
    input  logic [W-1:0]                  grf_rd1_i,
    input  logic [W-1:0]                  grf_rd2_i,
    input  logic [NBR*2*W-1:0]            nbr_tmp_i,
    input  logic                          tmp_we_i,
    input  logic                          tmp_widx_i,
    input  logic                          grf_req_i,
    input  logic [$clog2(GRF_DEPTH)-1:0]  grf_idx_i,
    input  logic                          mem_op_i,
    output logic [W-1:0]                  res_o,
    output logic [2*W-1:0]                tmp_o,
    output logic                          grf_we_o,
    output logic [$clog2(GRF_DEPTH)-1:0]  grf_widx_o,
    output logic [W-1:0]                  grf_wdata_o,
    output logic                          addr_valid_o
);

    localparam int GRF_AW   = $clog2(GRF_DEPTH);
    localparam int TMP_REGS = 2;
    localparam int NOPND    = 2;

    logic [W-1:0]      fur_q;
    logic [W-1:0]      alu_y;
    logic [W-1:0]      opnd   [NOPND];
    logic [1:0]        sel_v  [NOPND];
    logic [UNIT_W-1:0] unit_v [NOPND];
    logic [W-1:0]      grf_v  [NOPND];
    logic              grf_we_q;
    logic [GRF_AW-1:0] grf_idx_q;
    logic              addr_v_q;

    // Gather per-operand controls into arrays for the selector loop
    always_comb begin
        sel_v[0]  = src1_sel_i;
        sel_v[1]  = src2_sel_i;
        unit_v[0] = src1_unit_i;
        unit_v[1] = src2_unit_i;
        grf_v[0]  = grf_rd1_i;
        grf_v[1]  = grf_rd2_i;
    end

    // One operand selector per input
    generate
        for (genvar k = 0; k < NOPND; k++) begin : g_opnd
            mfu_opsel #(
                .W      (W),
                .NBR    (NBR),
                .UNIT_W (UNIT_W)
            ) u_opsel (
                .sel_i     (sel_v[k]),
                .unit_i    (unit_v[k]),
                .grf_i     (grf_v[k]),
                .nbr_tmp_i (nbr_tmp_i),
                .own_i     (fur_q),
                .opnd_o    (opnd[k])
            );
        end
    endgenerate

    mfu_alu #(.W(W)) u_alu (
        .op_i (op_code_i),
        .a_i  (opnd[0]),
        .b_i  (opnd[1]),
        .y_o  (alu_y)
    );

    mfu_tmpfile #(.W(W), .REGS(TMP_REGS)) u_tmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (op_valid_i && tmp_we_i),
        .idx_i   (tmp_widx_i),
        .wdata_i (alu_y),
        .rd_o    (tmp_o)
    );

    // Result register: latch every valid operation
    always_ff @(posedge clk) begin
        if (!rst_n)          fur_q <= '0;
        else if (op_valid_i) fur_q <= alu_y;
    end

    // Global write request and address flag, aligned with the result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grf_we_q  <= 1'b0;
            grf_idx_q <= '0;
            addr_v_q  <= 1'b0;
        end else begin
            grf_we_q <= op_valid_i && grf_req_i;
            addr_v_q <= op_valid_i && mem_op_i;
            if (op_valid_i && grf_req_i) grf_idx_q <= grf_idx_i;
        end
    end

    assign res_o        = fur_q;
    assign grf_we_o     = grf_we_q;
    assign grf_widx_o   = grf_idx_q;
    assign grf_wdata_o  = fur_q;
    assign addr_valid_o = addr_v_q;

    // R6: a valid operation lands in the result register next cycle
    assert_result_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> (res_o == $past(alu_y)));

    // R7: an idle slot leaves the result register alone
    assert_idle_holds_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(res_o));

    // R7: an idle slot leaves the scratch registers alone
    assert_idle_holds_tmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(tmp_o));

    // R9: a requested global write strobes with the index next cycle
    assert_grf_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && grf_req_i) |=> (grf_we_o && grf_widx_o == $past(grf_idx_i)));

    // R9: no strobe without a valid request
    assert_grf_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid_i && grf_req_i) |=> !grf_we_o);

    // R10: address flag follows a valid memory operation only
    assert_addr_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && mem_op_i) |=> addr_valid_o);

    // R5: pass forwards the selected first operand
    assert_pass_forwards_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_PASS) |=> (res_o == $past(opnd[0])));

    // R4: own-result source feeds back the current result register
    assert_own_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src1_sel_i == SRC_OWN) |-> (opnd[0] == res_o));

endmodule

// File: tb/tb_mfu_cell.sv
`timescale 1ns/1ps
module tb_mfu_cell;

    localparam int W   = 16;
    localparam int NBR = 2;
    localparam int UW  = 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           op_valid_i;
    logic [2:0]     op_code_i;
    logic [1:0]     src1_sel_i, src2_sel_i;
    logic [UW-1:0]  src1_unit_i, src2_unit_i;
    logic [W-1:0]   grf_rd1_i, grf_rd2_i;
    logic [NBR*2*W-1:0] nbr_tmp_i;
    logic           tmp_we_i, tmp_widx_i, grf_req_i, mem_op_i;
    logic [4:0]     grf_idx_i;
    logic [W-1:0]   res_o, grf_wdata_o;
    logic [2*W-1:0] tmp_o;
    logic           grf_we_o, addr_valid_o;
    logic [4:0]     grf_widx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    mfu_cell #(.W(W), .NBR(NBR), .GRF_DEPTH(32)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
        .src1_sel_i(src1_sel_i), .src2_sel_i(src2_sel_i),
        .src1_unit_i(src1_unit_i), .src2_unit_i(src2_unit_i),
        .grf_rd1_i(grf_rd1_i), .grf_rd2_i(grf_rd2_i), .nbr_tmp_i(nbr_tmp_i),
        .tmp_we_i(tmp_we_i), .tmp_widx_i(tmp_widx_i), .grf_req_i(grf_req_i),
        .grf_idx_i(grf_idx_i), .mem_op_i(mem_op_i), .res_o(res_o), .tmp_o(tmp_o),
        .grf_we_o(grf_we_o), .grf_widx_o(grf_widx_o), .grf_wdata_o(grf_wdata_o),
        .addr_valid_o(addr_valid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Load one slot; sideband controls default to off
    task automatic setop(input logic v, input logic [2:0] code, input logic [1:0] s1,
                         input logic [1:0] s2, input logic [W-1:0] g1, input logic [W-1:0] g2);
        op_valid_i = v; op_code_i = code; src1_sel_i = s1; src2_sel_i = s2;
        grf_rd1_i = g1; grf_rd2_i = g2; src1_unit_i = '0; src2_unit_i = '0;
        tmp_we_i = 0; tmp_widx_i = 0; grf_req_i = 0; grf_idx_i = '0; mem_op_i = 0;
    endtask

    // Advance one clock; outputs are sampled at the following falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 result", res_o, 0);
        chk("R1 tmp", tmp_o, 0);
        chk("R1 grf_we", grf_we_o, 0);
        chk("R1 addr", addr_valid_o, 0);
    endtask

    task automatic t_ops_global();
        setop(1, 3'b000, 2'b00, 2'b00, 16'hFFFF, 16'h0002); step();
        chk("R2 R11 add wrap", res_o, 16'h0001);
        setop(1, 3'b001, 2'b00, 2'b00, 16'h0003, 16'h0005); step();
        chk("R11 sub wrap", res_o, 16'hFFFE);
        setop(1, 3'b010, 2'b00, 2'b00, 16'hF0F0, 16'h3C3C); step();
        chk("R5 and", res_o, 16'h3030);
        setop(1, 3'b011, 2'b00, 2'b00, 16'hF000, 16'h000F); step();
        chk("R5 or", res_o, 16'hF00F);
        setop(1, 3'b100, 2'b00, 2'b00, 16'hFF00, 16'h0FF0); step();
        chk("R5 xor", res_o, 16'hF0F0);
        setop(1, 3'b101, 2'b00, 2'b00, 16'h0123, 16'h0004); step();
        chk("R5 shl", res_o, 16'h1230);
        setop(1, 3'b110, 2'b00, 2'b00, 16'h8000, 16'h000F); step();
        chk("R5 shr max", res_o, 16'h0001);
        setop(1, 3'b101, 2'b00, 2'b00, 16'h0001, 16'h0013); step();
        chk("R5 shamt low bits", res_o, 16'h0008);
        setop(1, 3'b111, 2'b00, 2'b00, 16'hBEEF, 16'h1234); step();
        chk("R5 pass", res_o, 16'hBEEF);
    endtask

    task automatic t_neighbour();
        nbr_tmp_i = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
        setop(1, 3'b100, 2'b10, 2'b01, 16'h0, 16'h0);
        src1_unit_i = 1; src2_unit_i = 0; step();
        chk("R3 u1t1 xor u0t0", res_o, 16'h5555);
        setop(1, 3'b001, 2'b01, 2'b10, 16'h0, 16'h0);
        src1_unit_i = 1; src2_unit_i = 0; step();
        chk("R3 u1t0 - u0t1", res_o, 16'h1111);
    endtask

    task automatic t_own();
        setop(1, 3'b111, 2'b00, 2'b00, 16'd5, 16'd0); step();
        setop(1, 3'b000, 2'b11, 2'b11, 16'd99, 16'd99); step();
        chk("R4 own+own", res_o, 16'd10);
        setop(1, 3'b001, 2'b11, 2'b00, 16'd99, 16'd3); step();
        chk("R4 own-grf", res_o, 16'd7);
    endtask

    task automatic t_tmp_write();
        setop(1, 3'b111, 2'b00, 2'b00, 16'hABCD, 16'h0);
        tmp_we_i = 1; tmp_widx_i = 0; step();
        chk("R8 tmp0 written", tmp_o, {16'h0000, 16'hABCD});
        chk("R6 result with tmp", res_o, 16'hABCD);
        setop(1, 3'b111, 2'b00, 2'b00, 16'h1234, 16'h0);
        tmp_we_i = 1; tmp_widx_i = 1; step();
        chk("R8 tmp1 written tmp0 kept", tmp_o, {16'h1234, 16'hABCD});
    endtask

    task automatic t_idle();
        setop(0, 3'b111, 2'b00, 2'b00, 16'hFFFF, 16'hFFFF);
        tmp_we_i = 1; tmp_widx_i = 0; grf_req_i = 1; grf_idx_i = 5'd9; mem_op_i = 1; step();
        chk("R7 result held", res_o, 16'h1234);
        chk("R7 tmp held", tmp_o, {16'h1234, 16'hABCD});
        chk("R7 no grf write", grf_we_o, 0);
        chk("R7 no addr", addr_valid_o, 0);
    endtask

    task automatic t_grf();
        setop(1, 3'b000, 2'b00, 2'b00, 16'h0100, 16'h0023);
        grf_req_i = 1; grf_idx_i = 5'd17; step();
        chk("R9 strobe", grf_we_o, 1);
        chk("R9 index", grf_widx_o, 5'd17);
        chk("R9 data", grf_wdata_o, 16'h0123);
        chk("R9 result same cycle", res_o, 16'h0123);
        setop(0, 3'b000, 2'b00, 2'b00, 16'h0, 16'h0); step();
        chk("R9 single pulse", grf_we_o, 0);
    endtask

    task automatic t_mem();
        setop(1, 3'b000, 2'b00, 2'b00, 16'h2000, 16'h0040); mem_op_i = 1; step();
        chk("R10 addr flag", addr_valid_o, 1);
        chk("R10 address", res_o, 16'h2040);
        setop(1, 3'b000, 2'b00, 2'b00, 16'h0001, 16'h0001); step();
        chk("R10 flag drops", addr_valid_o, 0);
    endtask

    task automatic t_reset_mid();
        setop(1, 3'b111, 2'b00, 2'b00, 16'h7777, 16'h0);
        tmp_we_i = 1; tmp_widx_i = 1; grf_req_i = 1; mem_op_i = 1;
        rst_n = 0; step();
        chk("R1 mid result", res_o, 0);
        chk("R1 mid tmp", tmp_o, 0);
        chk("R1 mid grf_we", grf_we_o, 0);
        chk("R1 mid addr", addr_valid_o, 0);
        setop(0, 3'b000, 2'b00, 2'b00, 16'h0, 16'h0);
        rst_n = 1; step();
    endtask

    initial begin
        rst_n = 0; nbr_tmp_i = '0;
        setop(0, 3'b000, 2'b00, 2'b00, 16'h0, 16'h0);
        step(); step();
        t_reset();
        rst_n = 1;
        t_ops_global();
        t_neighbour();
        t_own();
        t_tmp_write();
        t_idle();
        t_grf();
        t_mem();
        t_reset_mid();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule